// File: doc/BRIEF.md
# Pruned Polynomial Receiver Equalizer

This block sits right after a receiver's analog-to-digital converter and removes in-band intermodulation products that the analog front end adds. It accepts one offset-binary sample per clock when `valid_in` is high and converts it to two's complement. It keeps a sixteen-sample history of converted samples. Five processing elements each multiply two history samples, chosen by their own taps. Each element scales the product by a signed coefficient and shifts it right by its own power-of-two amount. A final adder sums the five element results with a delayed copy of the input sample and clips the total to sixteen bits.

Software programs the coefficients, taps and shifts through a write-only register port into a shadow bank. A one-cycle `commit` pulse copies the whole shadow bank into the working bank. Each sample carries the working settings it picked up on entry down the pipeline, so a commit never changes a sample that is already in flight. When every element has a zero coefficient, the block is a fixed-latency pass-through. Squares of one sample come from pointing both taps of an element at the same history slot.

Top module: `nleq_core`

## Requirements
- R1: An input code c (12 bits) is treated as the signed value c − 2048, which is the same as inverting its top bit. With all coefficients zero, y_out equals that value sign-extended to 16 bits.
- R2: `valid_out` is high exactly on the cycle after the fifth rising edge, counting the edge that samples `valid_in` high as the first. A sample taken at edge E appears at E+4, one result per accepted sample. `valid_in` is held low during reset.
- R3: The history advances only on edges where `valid_in` is high. Slot 0 holds the newest converted sample, slot k holds the sample accepted k samples earlier, and slots never written read as zero.
- R4: Each element contributes floor(x[a]·x[b]·h / 2^(11+s)). Here a and b are its taps (0..15), h is its signed 12-bit coefficient and s is its 4-bit shift.
- R5: y_out is the sum of the pass-through sample and the five contributions. A sum above 32767 gives 32767, and a sum below −32768 gives −32768.
- R6: A write with `wr_en` high goes to element `wr_addr[4:2]` (0..4). The field is chosen by `wr_addr[1:0]`: 0 is the coefficient from `wr_data[11:0]`, 1 is tap a from `wr_data[3:0]`, 2 is tap b from `wr_data[3:0]`, and 3 is the shift from `wr_data[3:0]`. Element indices 5..7 are ignored.
- R7: Writes change only the shadow bank. The working bank takes the shadow bank's contents as they stood before the edge at which `commit` is sampled high. A sample uses the working bank in force just after the edge that accepts it, so samples accepted before that commit edge keep the old settings.
- R8: After reset both banks are all zero, the history is zero, `valid_out` is low and `y_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | `din` carries a sample this cycle |
| din | input | 12 | Offset-binary converter sample |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | {element index, field select} |
| wr_data | input | 12 | Write data |
| commit | input | 1 | Copy shadow bank into working bank |
| valid_out | output | 1 | `y_out` carries a new result |
| y_out | output | 16 | Corrected, saturated sample (signed) |

## Verification
The assertions check several properties on every cycle. They check the fixed distance between `valid_in` and `valid_out`, and that the history shifts only on accepted samples. They also check that the working bank stays still without a commit, that a zero coefficient yields a zero weighted product, and that overflow clips to the rails. Only the bench's scenarios can show that the numbers are right. That covers the offset conversion, the tap-selected products, the floor rounding of each shift, and the exact sum against a behavioural model. The scenarios also show which samples see a commit that lands mid-stream, and that writes to unused element indices change nothing.

// File: rtl/nleq_pkg.sv
package nleq_pkg;
    localparam int XW     = 12;
    localparam int CW     = 12;
    localparam int SW     = 4;
    localparam int OW     = 16;
    localparam int DEPTH  = 16;
    localparam int NPE    = 5;
    localparam int TW     = $clog2(DEPTH);
    localparam int IDXW   = $clog2(NPE);
    localparam int ADDRW  = IDXW + 2;
    localparam int PW     = 2 * XW;
    localparam int WW     = PW + CW;
    localparam int NORM   = XW - 1;
    localparam int TERMW  = WW - NORM;
    localparam int ACCW   = TERMW + $clog2(NPE + 1) + 1;
    localparam int SHAMTW = $clog2(NORM + (1 << SW)) + 1;

    typedef enum logic [1:0] {
        FLD_COEF  = 2'd0,
        FLD_TAPA  = 2'd1,
        FLD_TAPB  = 2'd2,
        FLD_SHIFT = 2'd3
    } field_e;

    typedef struct packed {
        logic signed [CW-1:0] coef;
        logic [TW-1:0]        tap_a;
        logic [TW-1:0]        tap_b;
        logic [SW-1:0]        shift;
    } pe_cfg_t;
endpackage

// File: rtl/nleq_history.sv
module nleq_history
    import nleq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_in,
    input  logic [XW-1:0]        din,
    output logic                 valid_o,
    output logic signed [XW-1:0] hist [DEPTH]
);
    logic signed [XW-1:0] conv;

    always_comb begin
        conv = {~din[XW-1], din[XW-2:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist[0] <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= valid_in;
            if (valid_in) begin
                hist[0] <= conv;
            end
        end
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hist[k] <= '0;
            end else if (valid_in) begin
                hist[k] <= hist[k-1];
            end
        end
    end

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (hist[1] == $past(hist[0]))); // R3
    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(hist[DEPTH-1]) && $stable(hist[0])); // R3
endmodule

// File: rtl/nleq_cfg.sv
module nleq_cfg
    import nleq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADDRW-1:0] wr_addr,
    input  logic [CW-1:0]    wr_data,
    input  logic             commit,
    output pe_cfg_t          active [NPE]
);
    pe_cfg_t         shadow [NPE];
    logic [IDXW-1:0] sel_idx;
    field_e          sel_fld;

    always_comb begin
        sel_idx = wr_addr[ADDRW-1:2];
        sel_fld = field_e'(wr_addr[1:0]);
    end

    for (genvar g = 0; g < NPE; g++) begin : g_bank
        logic hit;
        always_comb begin
            hit = wr_en && (sel_idx == IDXW'(g));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow[g] <= '0;
            end else if (hit) begin
                unique case (sel_fld)
                    FLD_COEF:  shadow[g].coef  <= wr_data;
                    FLD_TAPA:  shadow[g].tap_a <= wr_data[TW-1:0];
                    FLD_TAPB:  shadow[g].tap_b <= wr_data[TW-1:0];
                    FLD_SHIFT: shadow[g].shift <= wr_data[SW-1:0];
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                active[g] <= '0;
            end else if (commit) begin
                active[g] <= shadow[g];
            end
        end

        AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !commit |=> $stable(active[g])); // R7
    end
endmodule

// File: rtl/nleq_pe.sv
module nleq_pe
    import nleq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [XW-1:0]    hist [DEPTH],
    input  pe_cfg_t                 cfg,
    output logic signed [TERMW-1:0] term
);
    logic signed [PW-1:0]  prod_r;
    logic signed [CW-1:0]  coef_r;
    logic [SW-1:0]         sh_p;
    logic [SW-1:0]         sh_w;
    logic signed [WW-1:0]  wgt_r;
    logic signed [WW-1:0]  shifted;
    logic [SHAMTW-1:0]     amt;

    always_comb begin
        amt     = SHAMTW'(NORM) + SHAMTW'(sh_w);
        shifted = wgt_r >>> amt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_r <= '0;
            coef_r <= '0;
            sh_p   <= '0;
            sh_w   <= '0;
            wgt_r  <= '0;
            term   <= '0;
        end else begin
            prod_r <= PW'(hist[cfg.tap_a]) * PW'(hist[cfg.tap_b]);
            coef_r <= cfg.coef;
            sh_p   <= cfg.shift;
            wgt_r  <= WW'(prod_r) * WW'(coef_r);
            sh_w   <= sh_p;
            term   <= shifted[TERMW-1:0];
        end
    end

    AST_ZERO_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_r == '0) |=> (wgt_r == '0)); // R4
endmodule

// File: rtl/nleq_sum.sv
module nleq_sum
    import nleq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    v_in,
    input  logic signed [XW-1:0]    pass,
    input  logic signed [TERMW-1:0] term [NPE],
    output logic                    v_out,
    output logic signed [OW-1:0]    y
);
    localparam logic signed [ACCW-1:0] SAT_HI = ACCW'((1 << (OW-1)) - 1);
    localparam logic signed [ACCW-1:0] SAT_LO = -SAT_HI - ACCW'(1);

    logic signed [ACCW-1:0] acc;
    logic signed [OW-1:0]   clip;

    always_comb begin
        acc = ACCW'(pass);
        for (int i = 0; i < NPE; i++) begin
            acc = acc + ACCW'(term[i]);
        end
        if (acc > SAT_HI) begin
            clip = SAT_HI[OW-1:0];
        end else if (acc < SAT_LO) begin
            clip = SAT_LO[OW-1:0];
        end else begin
            clip = acc[OW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_out <= 1'b0;
            y     <= '0;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                y <= clip;
            end
        end
    end

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && (acc > SAT_HI)) |=> (y == SAT_HI[OW-1:0])); // R5
    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && (acc < SAT_LO)) |=> (y == SAT_LO[OW-1:0])); // R5
endmodule

// File: rtl/nleq_core.sv
module nleq_core
    import nleq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_in,
    input  logic [XW-1:0]        din,
    input  logic                 wr_en,
    input  logic [ADDRW-1:0]     wr_addr,
    input  logic [CW-1:0]        wr_data,
    input  logic                 commit,
    output logic                 valid_out,
    output logic signed [OW-1:0] y_out
);
    logic signed [XW-1:0]    hist [DEPTH];
    logic                    v1;
    logic                    v2, v3, v4;
    logic signed [XW-1:0]    pt2, pt3, pt4;
    pe_cfg_t                 active [NPE];
    logic signed [TERMW-1:0] terms [NPE];

    nleq_history u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_in (valid_in),
        .din      (din),
        .valid_o  (v1),
        .hist     (hist)
    );

    nleq_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (commit),
        .active  (active)
    );

    for (genvar i = 0; i < NPE; i++) begin : g_pe
        nleq_pe u_pe (
            .clk   (clk),
            .rst_n (rst_n),
            .hist  (hist),
            .cfg   (active[i]),
            .term  (terms[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v2  <= 1'b0;
            v3  <= 1'b0;
            v4  <= 1'b0;
            pt2 <= '0;
            pt3 <= '0;
            pt4 <= '0;
        end else begin
            v2  <= v1;
            v3  <= v2;
            v4  <= v3;
            pt2 <= hist[0];
            pt3 <= pt2;
            pt4 <= pt3;
        end
    end

    nleq_sum u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .v_in  (v4),
        .pass  (pt4),
        .term  (terms),
        .v_out (valid_out),
        .y     (y_out)
    );

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(valid_in, 5) |-> valid_out); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid_in, 5) |-> !valid_out); // R2
endmodule

// File: tb/nleq_core_bench.sv
`timescale 1ns/1ps
module nleq_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [11:0] din = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        commit = 1'b0;
    logic        valid_out;
    logic signed [15:0] y_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string cur_req = "R1";

    int sh_coef [5], sh_ta [5], sh_tb [5], sh_sh [5];
    int ac_coef [5], ac_ta [5], ac_tb [5], ac_sh [5];
    int hx [16];
    bit ev [5];
    int ey [5];

    always #2 clk = ~clk;

    nleq_core u_nleq_core (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .din(din),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit),
        .valid_out(valid_out), .y_out(y_out)
    );

    function automatic int model_y();
        longint s = hx[0];
        for (int i = 0; i < 5; i++) begin
            longint p = longint'(hx[ac_ta[i]]) * longint'(hx[ac_tb[i]]) * longint'(ac_coef[i]);
            s += p >>> (11 + ac_sh[i]);
        end
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return int'(s);
    endfunction

    task automatic step(input bit v, input int d, input bit we, input int wa, input int wd, input bit cm);
        valid_in = v; din = d[11:0]; wr_en = we; wr_addr = wa[4:0]; wr_data = wd[11:0]; commit = cm;
        if (cm) for (int i = 0; i < 5; i++) begin
            ac_coef[i] = sh_coef[i]; ac_ta[i] = sh_ta[i]; ac_tb[i] = sh_tb[i]; ac_sh[i] = sh_sh[i];
        end
        if (we && (wa >> 2) < 5) begin
            int e = wa >> 2;
            case (wa & 3)
                0: sh_coef[e] = ((wd & 12'hFFF) >= 2048) ? (wd & 12'hFFF) - 4096 : (wd & 12'hFFF);
                1: sh_ta[e] = wd & 15;
                2: sh_tb[e] = wd & 15;
                default: sh_sh[e] = wd & 15;
            endcase
        end
        for (int k = 4; k > 0; k--) begin ev[k] = ev[k-1]; ey[k] = ey[k-1]; end
        ev[0] = v;
        if (v) begin
            for (int k = 15; k > 0; k--) hx[k] = hx[k-1];
            hx[0] = (d & 12'hFFF) - 2048;
            ey[0] = model_y();
        end
        @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (valid_out !== ev[4]) begin
            n_bad++;
            $display("FAIL R2 valid_out act=%0b exp=%0b", valid_out, ev[4]);
        end else if (ev[4] && (int'(y_out) != ey[4])) begin
            n_bad++;
            $display("FAIL %s y_out act=%0d exp=%0d", cur_req, y_out, ey[4]);
        end
    endtask

    task automatic wr(input int e, input int f, input int val);
        step(1'b0, 0, 1'b1, (e << 2) | f, val, 1'b0);
    endtask

    task automatic load_pe(input int e, input int h, input int a, input int b, input int s);
        wr(e, 0, h); wr(e, 1, a); wr(e, 2, b); wr(e, 3, s);
    endtask

    task automatic flush();
        for (int k = 0; k < 6; k++) step(1'b0, 0, 1'b0, 0, 0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) begin
            sh_coef[i] = 0; sh_ta[i] = 0; sh_tb[i] = 0; sh_sh[i] = 0;
            ac_coef[i] = 0; ac_ta[i] = 0; ac_tb[i] = 0; ac_sh[i] = 0;
            ev[i] = 0; ey[i] = 0;
        end
        for (int k = 0; k < 16; k++) hx[k] = 0;
        repeat (4) @(negedge clk);
        n_cmp++;
        if (valid_out !== 1'b0 || y_out !== 16'sd0) begin   // R8
            n_bad++;
            $display("FAIL R8 reset act=%0b/%0d exp=0/0", valid_out, y_out);
        end
        rst_n = 1'b1;

        // R1 / R8: zero banks give a pure pass-through, including the code extremes
        cur_req = "R1";
        step(1, 12'h000, 0, 0, 0, 0); step(1, 12'h800, 0, 0, 0, 0);
        step(1, 12'hFFF, 0, 0, 0, 0); step(1, 12'h7FF, 0, 0, 0, 0);
        for (int n = 0; n < 20; n++) step(1, $urandom & 12'hFFF, 0, 0, 0, 0);
        flush();

        // R7: shadow writes without commit leave output unchanged
        cur_req = "R7";
        load_pe(0, 12'h7FF, 0, 0, 0);
        for (int n = 0; n < 10; n++) step(1, $urandom & 12'hFFF, 0, 0, 0, 0);
        // commit in the middle of a stream; same-cycle sample uses new bank
        step(1, 12'hC00, 0, 0, 0, 1);
        for (int n = 0; n < 10; n++) step(1, $urandom & 12'hFFF, 0, 0, 0, 0);
        flush();

        // R6: indices 5..7 ignored
        cur_req = "R6";
        for (int e = 5; e < 8; e++) for (int f = 0; f < 4; f++) wr(e, f, $urandom & 12'hFFF);
        step(0, 0, 0, 0, 0, 1);
        for (int n = 0; n < 10; n++) step(1, $urandom & 12'hFFF, 0, 0, 0, 0);
        flush();

        // R4 / R3: random banks, random taps, gaps in valid_in
        for (int r = 0; r < 12; r++) begin
            cur_req = (r % 2 == 0) ? "R4" : "R3";
            for (int e = 0; e < 5; e++)
                load_pe(e, $urandom & 12'hFFF, $urandom & 15, $urandom & 15, 4 + ($urandom % 12));
            step(0, 0, 0, 0, 0, 1);
            for (int n = 0; n < 60; n++)
                step(($urandom % 4) != 0, $urandom & 12'hFFF, 0, 0, 0, ($urandom % 29) == 0);
            flush();
        end

        // R5: full-scale inputs drive the sum to both rails
        cur_req = "R5";
        for (int e = 1; e < 5; e++) load_pe(e, 0, 0, 0, 0);
        load_pe(0, 12'h800, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        step(1, 12'h000, 0, 0, 0, 0); step(1, 12'hFFF, 0, 0, 0, 0);
        step(1, 12'h800, 0, 0, 0, 0); step(1, 12'h000, 0, 0, 0, 0);
        load_pe(0, 12'h7FF, 0, 1, 0);
        step(0, 0, 0, 0, 0, 1);
        step(1, 12'h000, 0, 0, 0, 0); step(1, 12'h000, 0, 0, 0, 0);
        step(1, 12'hFFF, 0, 0, 0, 0); step(1, 12'hFFF, 0, 0, 0, 0);
        for (int n = 0; n < 30; n++)
            step(1, (($urandom % 2) != 0) ? 12'hFFF : 12'h000, 0, 0, 0, 0);
        flush();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule